// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-Stream Engine

This block walks a chain of descriptors in a word-addressed memory and turns the buffers they point at into packets on an outgoing word stream. Each descriptor holds a link to the next descriptor, a buffer pointer, a control word with a word-multiple byte length and frame-boundary flags, a status word, and five application words. A packet can span several descriptors. It opens on a descriptor flagged as first-of-frame, whose application words go out on a separate sideband stream before any data, and it closes on a descriptor flagged as last-of-frame.

A register block outside this engine supplies a run level, a start pulse, an abort pulse, a tail pointer and a way to load the current pointer. The engine reports frame completion, halt and idle as single-cycle pulses and exposes its current pointer. Every memory access is a request held until acknowledged, and every stream word is held until the sink accepts it. No packet storage exists beyond one word per stream.

Top module: `mts_dma`

## Requirements
- R1: While reset is high and in the cycle after it falls, `busy_o`, `mem_req_o`, `dat_valid_o`, `app_valid_o` and all three pulse outputs are 0 and `cur_ptr_o` is 0.
- R2: A start pulse while `run_i` is 0 is ignored: no memory request is issued and `busy_o` stays 0.
- R3: Status bit 31 marks a descriptor as complete. If the status word (byte offset 0x1C) of a fetched descriptor has bit 31 set, the engine pulses `halted_o`, moves no data, writes nothing, keeps `cur_ptr_o`, and waits for the next start. `halted_o` and `idle_o` never pulse together.
- R4: On a descriptor whose control word (offset 0x18) has bit 27 set, the five application words at offsets 0x20, 0x24, 0x28, 0x2C and 0x30 are sent in that order on the sideband stream before any data of that descriptor. `app_last_o` is 1 only with the fifth word.
- R5: Control bits 22:0 give the length in bytes (a multiple of 4). The engine reads that many bytes as words, upward from the buffer pointer (offset 0x08), and sends them in order. Words from successive descriptors join one packet. `dat_last_o` is 1 only on the final word of a descriptor whose control bit 26 is set.
- R6: After the data of a descriptor, the engine writes the word `{1, 8'b0, length}` (length ORed with bit 31) to that descriptor's offset 0x1C.
- R7: `frame_done_o` pulses once per descriptor with control bit 26 set, in the cycle after the status write for that descriptor is acknowledged.
- R8: After the status write, the current pointer takes the next-descriptor word (offset 0x00). If the descriptor just finished sits at `tail_i`, `idle_o` pulses and the walk stops. Otherwise the next descriptor is fetched.
- R9: While `dat_valid_o` or `app_valid_o` is 1 and its ready is 0, the word and its last flag stay unchanged in the next cycle.
- R10: An abort pulse returns the engine to waiting in the next cycle. It drops the memory request, clears both stream valids and leaves `cur_ptr_o` unchanged.
- R11: A pointer load is taken only while `busy_o` is 0. While a walk runs it has no effect on `cur_ptr_o`.
- R12: A descriptor with length 0 sends no data word. Its application words and status write still happen, and so does `frame_done_o` when control bit 26 is set.
- R13: A memory request keeps its address, write enable and data stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Engine enabled |
| start_i | input | 1 | Begin a walk at the current pointer |
| abort_i | input | 1 | Stop the walk and flush outputs |
| ptr_load_i | input | 1 | Load `ptr_val_i` into the current pointer |
| ptr_val_i | input | 32 | Pointer value to load |
| tail_i | input | 32 | Address of the last descriptor to process |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request done; read data valid |
| mem_rdata_i | input | 32 | Read data |
| dat_valid_o | output | 1 | Data stream word valid |
| dat_data_o | output | 32 | Data stream word |
| dat_last_o | output | 1 | Final word of packet |
| dat_ready_i | input | 1 | Data sink ready |
| app_valid_o | output | 1 | Sideband word valid |
| app_data_o | output | 32 | Sideband application word |
| app_last_o | output | 1 | Fifth application word |
| app_ready_i | input | 1 | Sideband sink ready |
| frame_done_o | output | 1 | Frame completion pulse |
| halted_o | output | 1 | Complete descriptor met pulse |
| idle_o | output | 1 | Tail reached pulse |
| cur_ptr_o | output | 32 | Current descriptor pointer |
| busy_o | output | 1 | Walk in progress |

## Verification
A read acknowledged at a clock edge puts its word on a stream output right after that edge, and the next request appears in the cycle after the sink takes the word. The bench sink records a transfer at the falling edge where it sees valid together with the ready it has just driven, so it always counts the edge where the transfer happens. `frame_done_o`, `halted_o` and `idle_o` are due one cycle after the acknowledge that causes them, and the bench checks each `frame_done_o` against a write acknowledged at the falling edge just before. The abort outcome is sampled at the first falling edge after the pulse, and memory latency is varied between 0 and 2 cycles across scenarios.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int PTR_W     = 32;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 23;
    localparam int APP_WORDS = 5;

    localparam logic [7:0] OFS_NEXT = 8'h00;
    localparam logic [7:0] OFS_BUFA = 8'h08;
    localparam logic [7:0] OFS_CTRL = 8'h18;
    localparam logic [7:0] OFS_STAT = 8'h1C;
    localparam logic [7:0] OFS_APP  = 8'h20;

    localparam int BIT_EOF  = 26;
    localparam int BIT_SOF  = 27;
    localparam int BIT_DONE = 31;

    typedef enum logic [2:0] {
        ST_WAIT,
        ST_FETCH,
        ST_APPRD,
        ST_APPWT,
        ST_DATRD,
        ST_DATWT,
        ST_WBACK
    } walk_st_t;

    typedef struct packed {
        logic [PTR_W-1:0] nxt;
        logic [PTR_W-1:0] bufa;
        logic             eof;
        logic [LEN_W-1:0] len;
    } desc_t;

    // Fetch order: status first, so a complete descriptor stops the walk early.
    function automatic logic [7:0] fetch_ofs(input logic [1:0] i);
        case (i)
            2'd0:    fetch_ofs = OFS_STAT;
            2'd1:    fetch_ofs = OFS_NEXT;
            2'd2:    fetch_ofs = OFS_BUFA;
            default: fetch_ofs = OFS_CTRL;
        endcase
    endfunction

endpackage

// File: rtl/mts_word_out.sv
module mts_word_out #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush_i,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    input  logic         dlast_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output logic         last_o,
    input  logic         ready_i,
    output logic         free_o
);

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            valid_o <= 1'b0;
            data_o  <= '0;
            last_o  <= 1'b0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            data_o  <= din_i;
            last_o  <= dlast_i;
        end else if (ready_i) begin
            valid_o <= 1'b0;
        end
    end

    assign free_o = !valid_o || ready_i;

    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst || flush_i)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));

endmodule

// File: rtl/mts_desc_latch.sv
module mts_desc_latch
    import mts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [1:0]        fidx_i,
    input  logic [WORD_W-1:0] word_i,
    output desc_t             desc_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_o <= '0;
        end else if (cap_i) begin
            case (fidx_i)
                2'd1: desc_o.nxt  <= word_i[PTR_W-1:0];
                2'd2: desc_o.bufa <= word_i[PTR_W-1:0];
                2'd3: begin
                    desc_o.eof <= word_i[BIT_EOF];
                    desc_o.len <= word_i[LEN_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mts_walk_ctrl.sv
module mts_walk_ctrl
    import mts_pkg::*;
#(
    parameter int NAPP = APP_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              ptr_load_i,
    input  logic [PTR_W-1:0]  ptr_val_i,
    input  logic [PTR_W-1:0]  tail_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic              rd_done_i,
    input  logic              rd_sof_i,
    input  logic [LEN_W-1:0]  rd_len_i,
    input  desc_t             desc_i,
    output logic              cap_o,
    output logic [1:0]        fidx_o,
    output logic              dat_load_o,
    output logic              dat_last_o,
    input  logic              dat_free_i,
    output logic              app_load_o,
    output logic              app_last_o,
    input  logic              app_free_i,
    output logic              frame_done_o,
    output logic              halted_o,
    output logic              idle_o,
    output logic [PTR_W-1:0]  cur_ptr_o,
    output logic              busy_o
);

    localparam int WCNT_W = LEN_W - 2;
    localparam int IDX_W  = (NAPP > 4) ? $clog2(NAPP) : 2;
    localparam logic [IDX_W-1:0] IDX_APP_END = IDX_W'(NAPP - 1);
    localparam logic [IDX_W-1:0] IDX_FETCH_END = IDX_W'(3);

    walk_st_t           st_q;
    logic [IDX_W-1:0]   idx_q;
    logic [WCNT_W-1:0]  wcnt_q;
    logic [PTR_W-1:0]   bufp_q;
    logic [PTR_W-1:0]   cur_q;
    logic               done_q, halt_q, idle_q;

    logic [LEN_W-1:0]   ent_len;
    logic [WCNT_W-1:0]  ent_words;

    // Length in force when entering the data phase: straight from memory on
    // the control fetch, from the latch after the application words.
    assign ent_len   = (st_q == ST_FETCH) ? rd_len_i : desc_i.len;
    assign ent_words = ent_len[LEN_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_WAIT;
            idx_q  <= '0;
            wcnt_q <= '0;
            bufp_q <= '0;
            cur_q  <= '0;
            done_q <= 1'b0;
            halt_q <= 1'b0;
            idle_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            halt_q <= 1'b0;
            idle_q <= 1'b0;
            if (abort_i) begin
                st_q  <= ST_WAIT;
                idx_q <= '0;
            end else begin
                case (st_q)
                    ST_WAIT: begin
                        if (ptr_load_i) cur_q <= ptr_val_i;
                        if (start_i && run_i) begin
                            st_q  <= ST_FETCH;
                            idx_q <= '0;
                        end
                    end
                    ST_FETCH: begin
                        if (mem_ack_i) begin
                            if (idx_q == '0 && rd_done_i) begin
                                halt_q <= 1'b1;
                                st_q   <= ST_WAIT;
                            end else if (idx_q == IDX_FETCH_END) begin
                                if (rd_sof_i) begin
                                    st_q  <= ST_APPRD;
                                    idx_q <= '0;
                                end else begin
                                    bufp_q <= desc_i.bufa;
                                    wcnt_q <= ent_words;
                                    st_q   <= (ent_words == '0) ? ST_WBACK : ST_DATRD;
                                end
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end
                    end
                    ST_APPRD: begin
                        if (mem_ack_i) st_q <= ST_APPWT;
                    end
                    ST_APPWT: begin
                        if (app_free_i) begin
                            if (idx_q == IDX_APP_END) begin
                                bufp_q <= desc_i.bufa;
                                wcnt_q <= ent_words;
                                st_q   <= (ent_words == '0) ? ST_WBACK : ST_DATRD;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                                st_q  <= ST_APPRD;
                            end
                        end
                    end
                    ST_DATRD: begin
                        if (mem_ack_i) begin
                            bufp_q <= bufp_q + PTR_W'(4);
                            wcnt_q <= wcnt_q - 1'b1;
                            st_q   <= ST_DATWT;
                        end
                    end
                    ST_DATWT: begin
                        if (dat_free_i) st_q <= (wcnt_q == '0) ? ST_WBACK : ST_DATRD;
                    end
                    ST_WBACK: begin
                        if (mem_ack_i) begin
                            done_q <= desc_i.eof;
                            cur_q  <= desc_i.nxt;
                            idx_q  <= '0;
                            if (cur_q == tail_i) begin
                                idle_q <= 1'b1;
                                st_q   <= ST_WAIT;
                            end else begin
                                st_q <= ST_FETCH;
                            end
                        end
                    end
                    default: st_q <= ST_WAIT;
                endcase
            end
        end
    end

    always_comb begin
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = cur_q;
        case (st_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + PTR_W'(fetch_ofs(idx_q[1:0]));
            end
            ST_APPRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = cur_q + PTR_W'(OFS_APP) + PTR_W'({idx_q, 2'b00});
            end
            ST_DATRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = bufp_q;
            end
            ST_WBACK: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = cur_q + PTR_W'(OFS_STAT);
            end
            default: ;
        endcase
    end

    assign mem_wdata_o  = {1'b1, {(WORD_W-1-LEN_W){1'b0}}, desc_i.len};
    assign cap_o        = (st_q == ST_FETCH) && mem_ack_i;
    assign fidx_o       = idx_q[1:0];
    assign dat_load_o   = (st_q == ST_DATRD) && mem_ack_i;
    assign dat_last_o   = desc_i.eof && (wcnt_q == WCNT_W'(1));
    assign app_load_o   = (st_q == ST_APPRD) && mem_ack_i;
    assign app_last_o   = (idx_q == IDX_APP_END);
    assign frame_done_o = done_q;
    assign halted_o     = halt_q;
    assign idle_o       = idle_q;
    assign cur_ptr_o    = cur_q;
    assign busy_o       = (st_q != ST_WAIT);

    assert_req_stable_R13: assert property (@(posedge clk) disable iff (rst || abort_i)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_norun_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !(start_i && run_i)) |=> !mem_req_o);

    assert_halt_idle_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(halted_o && idle_o));

    assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |-> $past(mem_we_o && mem_ack_i));

    assert_idle_at_tail_R8: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> ($past(cur_q) == $past(tail_i)));

endmodule

// File: rtl/mts_dma.sv
module mts_dma
    import mts_pkg::*;
#(
    parameter int NAPP = APP_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              ptr_load_i,
    input  logic [PTR_W-1:0]  ptr_val_i,
    input  logic [PTR_W-1:0]  tail_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              dat_valid_o,
    output logic [WORD_W-1:0] dat_data_o,
    output logic              dat_last_o,
    input  logic              dat_ready_i,
    output logic              app_valid_o,
    output logic [WORD_W-1:0] app_data_o,
    output logic              app_last_o,
    input  logic              app_ready_i,
    output logic              frame_done_o,
    output logic              halted_o,
    output logic              idle_o,
    output logic [PTR_W-1:0]  cur_ptr_o,
    output logic              busy_o
);

    desc_t      desc;
    logic       cap;
    logic [1:0] fidx;
    logic       dat_load, dat_last_n, dat_free;
    logic       app_load, app_last_n, app_free;

    mts_walk_ctrl #(.NAPP(NAPP)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run_i),
        .start_i      (start_i),
        .abort_i      (abort_i),
        .ptr_load_i   (ptr_load_i),
        .ptr_val_i    (ptr_val_i),
        .tail_i       (tail_i),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_ack_i    (mem_ack_i),
        .rd_done_i    (mem_rdata_i[BIT_DONE]),
        .rd_sof_i     (mem_rdata_i[BIT_SOF]),
        .rd_len_i     (mem_rdata_i[LEN_W-1:0]),
        .desc_i       (desc),
        .cap_o        (cap),
        .fidx_o       (fidx),
        .dat_load_o   (dat_load),
        .dat_last_o   (dat_last_n),
        .dat_free_i   (dat_free),
        .app_load_o   (app_load),
        .app_last_o   (app_last_n),
        .app_free_i   (app_free),
        .frame_done_o (frame_done_o),
        .halted_o     (halted_o),
        .idle_o       (idle_o),
        .cur_ptr_o    (cur_ptr_o),
        .busy_o       (busy_o)
    );

    mts_desc_latch u_desc (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .fidx_i (fidx),
        .word_i (mem_rdata_i),
        .desc_o (desc)
    );

    mts_word_out #(.W(WORD_W)) u_dat (
        .clk     (clk),
        .rst     (rst),
        .flush_i (abort_i),
        .load_i  (dat_load),
        .din_i   (mem_rdata_i),
        .dlast_i (dat_last_n),
        .valid_o (dat_valid_o),
        .data_o  (dat_data_o),
        .last_o  (dat_last_o),
        .ready_i (dat_ready_i),
        .free_o  (dat_free)
    );

    mts_word_out #(.W(WORD_W)) u_app (
        .clk     (clk),
        .rst     (rst),
        .flush_i (abort_i),
        .load_i  (app_load),
        .din_i   (mem_rdata_i),
        .dlast_i (app_last_n),
        .valid_o (app_valid_o),
        .data_o  (app_data_o),
        .last_o  (app_last_o),
        .ready_i (app_ready_i),
        .free_o  (app_free)
    );

    assert_abort_flush_R10: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (!busy_o && !dat_valid_o && !app_valid_o && !mem_req_o));

endmodule

// File: tb/sim_mts_dma.sv
module sim_mts_dma;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0, start_i = 1'b0, abort_i = 1'b0, ptr_load_i = 1'b0;
    logic [31:0] ptr_val_i = '0, tail_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        dat_valid_o, dat_last_o, dat_ready_i = 1'b1;
    logic [31:0] dat_data_o;
    logic        app_valid_o, app_last_o, app_ready_i = 1'b1;
    logic [31:0] app_data_o;
    logic        frame_done_o, halted_o, idle_o, busy_o;
    logic [31:0] cur_ptr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mts_dma u0 (
        .clk(clk), .rst(rst), .run_i(run_i), .start_i(start_i), .abort_i(abort_i),
        .ptr_load_i(ptr_load_i), .ptr_val_i(ptr_val_i), .tail_i(tail_i),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .dat_valid_o(dat_valid_o), .dat_data_o(dat_data_o), .dat_last_o(dat_last_o),
        .dat_ready_i(dat_ready_i), .app_valid_o(app_valid_o), .app_data_o(app_data_o),
        .app_last_o(app_last_o), .app_ready_i(app_ready_i),
        .frame_done_o(frame_done_o), .halted_o(halted_o), .idle_o(idle_o),
        .cur_ptr_o(cur_ptr_o), .busy_o(busy_o)
    );

    int checks = 0;
    int failures = 0;

    // memory model and sinks
    logic [31:0] mem [0:1023];
    int          lat = 0;
    int          wait_cnt = 0;
    bit          prev_wr_ack = 1'b0;
    int          req_seen = 0, wr_seen = 0;
    int          rdy_mode = 0;
    int          cyc = 0;
    logic [31:0] dq [0:63];
    bit          dl [0:63];
    logic [31:0] aq [0:63];
    bit          al [0:63];
    int          dn = 0, an = 0;
    bit          app_before_dat = 1'b1;
    int          n_done = 0, n_halt = 0, n_idle = 0;
    bit          done_timing_ok = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_done_o) begin
                n_done++;
                if (!prev_wr_ack) done_timing_ok = 1'b0;
            end
            if (halted_o) n_halt++;
            if (idle_o) n_idle++;
            if (mem_req_o) req_seen++;
        end
        prev_wr_ack = 1'b0;
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
        end else if (mem_req_o) begin
            if (wait_cnt >= lat) begin
                mem_ack_i = 1'b1;
                wait_cnt = 0;
                if (mem_we_o) begin
                    mem[mem_addr_o[11:2]] = mem_wdata_o;
                    prev_wr_ack = 1'b1;
                    wr_seen++;
                end else begin
                    mem_rdata_i = mem[mem_addr_o[11:2]];
                end
            end else begin
                wait_cnt++;
            end
        end else begin
            wait_cnt = 0;
        end
        case (rdy_mode)
            0: begin dat_ready_i = 1'b1; app_ready_i = 1'b1; end
            1: begin dat_ready_i = (cyc % 3) != 0; app_ready_i = (cyc % 2) == 0; end
            default: begin dat_ready_i = 1'b0; app_ready_i = 1'b1; end
        endcase
        if (dat_valid_o && dat_ready_i) begin
            if (an % 5 != 0) app_before_dat = 1'b0;
            if (dn < 64) begin dq[dn] = dat_data_o; dl[dn] = dat_last_o; end
            dn++;
        end
        if (app_valid_o && app_ready_i) begin
            if (an < 64) begin aq[an] = app_data_o; al[an] = app_last_o; end
            an++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        dn = 0; an = 0; n_done = 0; n_halt = 0; n_idle = 0;
        req_seen = 0; wr_seen = 0; app_before_dat = 1'b1; done_timing_ok = 1'b1;
    endtask

    task automatic put_desc(input int base, input int nxt, input int bufa,
                            input logic [31:0] ctl, input logic [31:0] stat, input int appv);
        mem[base/4 + 0] = nxt;
        mem[base/4 + 2] = bufa;
        mem[base/4 + 6] = ctl;
        mem[base/4 + 7] = stat;
        for (int k = 0; k < 5; k++) mem[base/4 + 8 + k] = appv + k;
    endtask

    task automatic go(input int ptr, input int tail);
        @(negedge clk);
        ptr_load_i = 1'b1; ptr_val_i = ptr; tail_i = tail;
        @(negedge clk);
        ptr_load_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_quiet();
        for (int t = 0; t < 4000 && busy_o; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !dat_valid_o && !app_valid_o, "R1 quiet in reset",
            {28'b0, busy_o, mem_req_o, dat_valid_o, app_valid_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!frame_done_o && !halted_o && !idle_o && cur_ptr_o == 0, "R1 after reset",
            cur_ptr_o, 0);
    endtask

    task automatic t_norun();
        clear_logs();
        run_i = 1'b0;
        go(32'h100, 32'h100);
        repeat (20) @(negedge clk);
        chk(req_seen == 0, "R2 no request without run", req_seen, 0);
        chk(!busy_o, "R2 busy stays low", busy_o, 0);
    endtask

    task automatic t_multi_desc_frame();
        clear_logs();
        lat = 0; rdy_mode = 1; run_i = 1'b1;
        put_desc(32'h100, 32'h140, 32'h400, (1 << 27) | 12, 0, 32'hA0);
        put_desc(32'h140, 32'h180, 32'h500, (1 << 26) | 8, 0, 32'hB0);
        for (int k = 0; k < 3; k++) mem[32'h400/4 + k] = 32'h1000 + k;
        for (int k = 0; k < 2; k++) mem[32'h500/4 + k] = 32'h2000 + k;
        go(32'h100, 32'h140);
        wait_quiet();
        chk(an == 5, "R4 five app words", an, 5);
        for (int k = 0; k < 5; k++) begin
            chk(aq[k] == 32'hA0 + k, "R4 app word order", aq[k], 32'hA0 + k);
            chk(al[k] == (k == 4), "R4 app last flag", al[k], k == 4);
        end
        chk(app_before_dat, "R4 app words precede data", app_before_dat, 1);
        chk(dn == 5, "R5 data word count", dn, 5);
        for (int k = 0; k < 5; k++) begin
            logic [31:0] e;
            e = (k < 3) ? 32'h1000 + k : 32'h2000 + k - 3;
            chk(dq[k] == e, "R5 R9 data word under backpressure", dq[k], e);
            chk(dl[k] == (k == 4), "R5 last only at frame end", dl[k], k == 4);
        end
        chk(mem[32'h11C/4] == 32'h8000000C, "R6 first status", mem[32'h11C/4], 32'h8000000C);
        chk(mem[32'h15C/4] == 32'h80000008, "R6 second status", mem[32'h15C/4], 32'h80000008);
        chk(n_done == 1 && done_timing_ok, "R7 one frame pulse after status write", n_done, 1);
        chk(n_idle == 1 && n_halt == 0, "R8 idle at tail", n_idle, 1);
        chk(cur_ptr_o == 32'h180, "R8 pointer follows link", cur_ptr_o, 32'h180);
    endtask

    task automatic t_halt();
        clear_logs();
        lat = 1; rdy_mode = 0;
        put_desc(32'h200, 32'h240, 32'h600, (1 << 27) | (1 << 26) | 4, 32'h80000001, 32'hC0);
        go(32'h200, 32'h200);
        wait_quiet();
        chk(n_halt == 1 && n_idle == 0, "R3 halt pulse", n_halt, 1);
        chk(dn == 0 && an == 0, "R3 no data moved", dn + an, 0);
        chk(wr_seen == 0, "R3 no write", wr_seen, 0);
        chk(mem[32'h21C/4] == 32'h80000001, "R3 status untouched", mem[32'h21C/4], 32'h80000001);
        chk(cur_ptr_o == 32'h200, "R3 pointer kept", cur_ptr_o, 32'h200);
    endtask

    task automatic t_zero_len_chain();
        clear_logs();
        lat = 2; rdy_mode = 0;
        put_desc(32'h300, 32'h340, 32'h700, (1 << 27) | (1 << 26) | 4, 0, 32'hD0);
        put_desc(32'h340, 32'h380, 32'h780, (1 << 27) | (1 << 26) | 0, 0, 32'hE0);
        put_desc(32'h380, 32'h3C0, 32'h7C0, (1 << 26) | 4, 32'h80000000, 32'hF0);
        mem[32'h700/4] = 32'h3000;
        go(32'h300, 32'h3C0);
        wait_quiet();
        chk(dn == 1 && dq[0] == 32'h3000 && dl[0], "R12 only one data word", dn, 1);
        chk(an == 10 && aq[5] == 32'hE0, "R12 app words of empty descriptor", an, 10);
        chk(mem[32'h35C/4] == 32'h80000000, "R12 R6 empty status", mem[32'h35C/4], 32'h80000000);
        chk(n_done == 2 && done_timing_ok, "R7 R12 two frame pulses", n_done, 2);
        chk(n_halt == 1 && n_idle == 0, "R3 chain ends on complete", n_halt, 1);
        chk(cur_ptr_o == 32'h380, "R8 pointer at complete descriptor", cur_ptr_o, 32'h380);
    endtask

    task automatic t_abort();
        clear_logs();
        lat = 0; rdy_mode = 2;
        put_desc(32'h800, 32'h840, 32'h900, (1 << 26) | 160, 0, 32'h0);
        mem[32'h81C/4] = 32'h0;
        go(32'h800, 32'h800);
        repeat (30) @(negedge clk);
        chk(busy_o && dat_valid_o, "R9 stalled with word held", {30'b0, busy_o, dat_valid_o}, 3);
        ptr_load_i = 1'b1; ptr_val_i = 32'h999;
        @(negedge clk);
        ptr_load_i = 1'b0;
        @(negedge clk);
        chk(cur_ptr_o == 32'h800, "R11 load ignored while busy", cur_ptr_o, 32'h800);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        chk(!busy_o && !dat_valid_o && !app_valid_o && !mem_req_o, "R10 abort flush",
            {28'b0, busy_o, dat_valid_o, app_valid_o, mem_req_o}, 0);
        chk(cur_ptr_o == 32'h800, "R10 pointer kept on abort", cur_ptr_o, 32'h800);
        repeat (5) @(negedge clk);
        chk(mem[32'h81C/4] == 0 && n_done == 0, "R10 no write-back after abort", mem[32'h81C/4], 0);
        rdy_mode = 0;
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        t_reset();
        t_norun();
        t_multi_desc_frame();
        t_halt();
        t_zero_len_chain();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule